// File: doc/BRIEF.md
# Periodic Interrupt Pulse Generator

This block turns one of four periodic timing events from a clock/calendar counter chain into an active-low output pin, plus a status flag that software reads. A two-bit rate select picks which event drives the pin: the 64 Hz event, the once-per-second event, the once-per-minute event or the once-per-hour event. The events themselves come from counters outside this block, as single-cycle strobes.

The pin works in one of two modes. In latched-interrupt mode, an accepted event drives the pin low, and the pin stays low until software acknowledges the event by writing 0 to the status flag. In fixed-pulse mode, the pin goes low for a fixed number of periods of the 32.768 kHz enable and then returns high by itself. The default is 256 periods, which is 7.8125 ms. A 0 written to the flag also ends the pulse early.

The status flag always reads as the inverse of the pin. Only hardware can set it. An event that arrives while the flag is already set is discarded. A mask input blocks new events. A stop input freezes the fixed-pulse timing, both the start of a new pulse and the countdown of the current one.

Top module: `stdp_pulse_gen`

## Requirements
- R1: `rate_sel` selects the event that may set the flag: 0 selects `evt_64hz`, 1 selects `evt_sec`, 2 selects `evt_min` and 3 selects `evt_hour`. A strobe on any line that is not selected has no effect on the flag.
- R2: `pulse_n` is always the inverse of `irq_flag`.
- R3: With `irq_mode`=1, a set flag stays set for any number of `tick_en` strobes until software clears it.
- R4: With `irq_mode`=0 and `stop`=0, a set flag clears on the PULSE_TICKS-th `tick_en` strobe that is sampled while the flag is set. The flag does not clear on any earlier strobe.
- R5: While `mask`=1, no event sets the flag. A flag that is already set is not cleared by the mask.
- R6: With `irq_mode`=0 and `stop`=1, events are not accepted and `tick_en` strobes are not counted. When `stop` returns to 0, the pulse continues with the count of strobes it still has left.
- R7: A cycle with `irq_wr`=1 and `irq_wr_data`=0 clears the flag in every mode, including while `stop`=1. A write with `irq_wr_data`=1 never sets the flag.
- R8: An event that arrives while the flag is set is dropped. It does not lengthen a fixed pulse, it does not set the flag again after a clear, and an event in the same cycle as a clear leaves the flag at 0.
- R9: While `rst` is high and after it goes low, the flag is 0 and `pulse_n` is 1 until an event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| evt_64hz | input | 1 | 1/64 s event strobe |
| evt_sec | input | 1 | 1 s event strobe |
| evt_min | input | 1 | 1 min event strobe |
| evt_hour | input | 1 | 1 h event strobe |
| rate_sel | input | 2 | Event rate select |
| irq_mode | input | 1 | 1 = latched interrupt, 0 = fixed-width pulse |
| mask | input | 1 | 1 blocks new events |
| stop | input | 1 | 1 freezes fixed-pulse timing |
| irq_wr | input | 1 | Software write strobe to the flag |
| irq_wr_data | input | 1 | Value written; only 0 has an effect |
| pulse_n | output | 1 | Active-low output pin |
| irq_flag | output | 1 | Status flag, inverse of pin |

## Verification
The hardest situation to reach is a fixed pulse that a stop period interrupts partway through, so that the remaining count has to survive the freeze. The bench starts a pulse and consumes a known number of strobes. It then raises `stop`, keeps feeding strobes for several full pulse lengths, drops `stop`, and counts the strobes until release, which must equal the remainder. Strobe spacing varies between runs, so the width is measured in strobes and not in clock cycles.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    typedef enum logic [1:0] {
        RATE_64HZ = 2'd0,
        RATE_SEC  = 2'd1,
        RATE_MIN  = 2'd2,
        RATE_HOUR = 2'd3
    } rate_e;

    typedef struct packed {
        logic hz64;
        logic sec;
        logic min;
        logic hour;
    } evt_s;

    typedef struct packed {
        logic irq_mode;
        logic mask;
        logic stop;
    } ctrl_s;

    function automatic logic pick_event(input evt_s ev, input rate_e r);
        logic hit;
        case (r)
            RATE_64HZ: hit = ev.hz64;
            RATE_SEC:  hit = ev.sec;
            RATE_MIN:  hit = ev.min;
            default:   hit = ev.hour;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/stdp_evt_gate.sv
module stdp_evt_gate
    import stdp_pkg::*;
(
    input  evt_s  events,
    input  rate_e rate,
    input  ctrl_s ctrl,
    input  logic  pending,
    output logic  accept
);
    logic chosen;
    logic frozen;

    always_comb begin
        chosen = pick_event(events, rate);
        frozen = ctrl.stop && !ctrl.irq_mode;
        accept = chosen && !ctrl.mask && !frozen && !pending;
    end
endmodule

// File: rtl/stdp_width_timer.sv
module stdp_width_timer #(
    parameter int PULSE_TICKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = (PULSE_TICKS > 2) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_TICKS - 1);

    logic [CW-1:0] remain;

    assign expire = run && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= LOAD_VAL;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/stdp_flag_ctrl.sv
module stdp_flag_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic sw_clear,
    input  logic expire,
    input  logic accept,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (sw_clear || expire) begin
            flag <= 1'b0;
        end else if (accept) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/stdp_pulse_gen.sv
module stdp_pulse_gen
    import stdp_pkg::*;
#(
    parameter int PULSE_TICKS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       evt_64hz,
    input  logic       evt_sec,
    input  logic       evt_min,
    input  logic       evt_hour,
    input  logic [1:0] rate_sel,
    input  logic       irq_mode,
    input  logic       mask,
    input  logic       stop,
    input  logic       irq_wr,
    input  logic       irq_wr_data,
    output logic       pulse_n,
    output logic       irq_flag
);
    evt_s  events;
    ctrl_s ctrl;
    logic  flag_q;
    logic  accept;
    logic  expire;
    logic  sw_clear;
    logic  timer_run;

    always_comb begin
        events    = '{hz64: evt_64hz, sec: evt_sec, min: evt_min, hour: evt_hour};
        ctrl      = '{irq_mode: irq_mode, mask: mask, stop: stop};
        sw_clear  = irq_wr && !irq_wr_data;
        timer_run = flag_q && tick_en && !ctrl.irq_mode && !ctrl.stop;
    end

    stdp_evt_gate u_gate (
        .events (events),
        .rate   (rate_e'(rate_sel)),
        .ctrl   (ctrl),
        .pending(flag_q),
        .accept (accept)
    );

    stdp_width_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .run   (timer_run),
        .expire(expire)
    );

    stdp_flag_ctrl u_flag (
        .clk     (clk),
        .rst     (rst),
        .sw_clear(sw_clear),
        .expire  (expire),
        .accept  (accept),
        .flag    (flag_q)
    );

    assign irq_flag = flag_q;
    assign pulse_n  = ~flag_q;
endmodule

// File: rtl/stdp_pulse_chk.sv
module stdp_pulse_chk (
    input logic       clk,
    input logic       rst,
    input logic       evt_64hz,
    input logic       evt_sec,
    input logic       evt_min,
    input logic       evt_hour,
    input logic [1:0] rate_sel,
    input logic       irq_mode,
    input logic       mask,
    input logic       stop,
    input logic       irq_wr,
    input logic       irq_wr_data,
    input logic       irq_flag
);
    logic sel_evt;
    logic clr;

    always_comb begin
        case (rate_sel)
            2'd0:    sel_evt = evt_64hz;
            2'd1:    sel_evt = evt_sec;
            2'd2:    sel_evt = evt_min;
            default: sel_evt = evt_hour;
        endcase
        clr = irq_wr && !irq_wr_data;
    end

    AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!irq_flag && !sel_evt) |=> !irq_flag); // R1

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (mask && !irq_flag) |=> !irq_flag); // R5

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && irq_mode && !clr) |=> irq_flag); // R3

    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> !irq_flag); // R7

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (stop && !irq_mode && !clr) |=> $stable(irq_flag)); // R6

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> !irq_flag); // R9
endmodule

bind stdp_pulse_gen stdp_pulse_chk u_chk (.*);

// File: tb/tb_stdp_pulse_gen.sv
`timescale 1ns/1ps
module tb_stdp_pulse_gen;
    localparam int PT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       evt_64hz = 1'b0, evt_sec = 1'b0, evt_min = 1'b0, evt_hour = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       irq_mode = 1'b0, mask = 1'b0, stop = 1'b0;
    logic       irq_wr = 1'b0, irq_wr_data = 1'b0;
    logic       pulse_n, irq_flag;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stdp_pulse_gen #(.PULSE_TICKS(PT)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .evt_64hz(evt_64hz), .evt_sec(evt_sec), .evt_min(evt_min), .evt_hour(evt_hour),
        .rate_sel(rate_sel), .irq_mode(irq_mode), .mask(mask), .stop(stop),
        .irq_wr(irq_wr), .irq_wr_data(irq_wr_data),
        .pulse_n(pulse_n), .irq_flag(irq_flag)
    );

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_flag(input string tag, input logic exp);
        chk(tag, irq_flag, exp);
        chk({tag, " R2 pin"}, pulse_n, !exp);
    endtask

    task automatic step(input logic tk);
        tick_en = tk;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_line(input int line, input logic v);
        case (line)
            0: evt_64hz = v;
            1: evt_sec  = v;
            2: evt_min  = v;
            default: evt_hour = v;
        endcase
    endtask

    task automatic fire(input int line);
        set_line(line, 1'b1);
        step(1'b0);
        set_line(line, 1'b0);
    endtask

    task automatic swr(input logic d);
        irq_wr = 1'b1;
        irq_wr_data = d;
        step(1'b0);
        irq_wr = 1'b0;
        irq_wr_data = 1'b0;
    endtask

    // counts tick strobes consumed while low, spaced every 'period' cycles
    task automatic measure(input int period, output int ticks);
        ticks = 0;
        for (int c = 0; c < 4000; c++) begin
            if (pulse_n) break;
            tick_en = ((c % period) == period - 1);
            if (tick_en) ticks++;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        int t;
        repeat (3) @(negedge clk);
        chk_flag("R9 in reset", 1'b0);
        rst = 1'b0;
        step(1'b0);
        chk_flag("R9 after reset", 1'b0);

        // R1/R5 sweep: mode x mask x rate x event line
        for (int m = 0; m < 2; m++)
            for (int mk = 0; mk < 2; mk++)
                for (int r = 0; r < 4; r++)
                    for (int l = 0; l < 4; l++) begin
                        irq_mode = m[0];
                        mask = mk[0];
                        rate_sel = r[1:0];
                        swr(1'b0);
                        fire(l);
                        chk_flag($sformatf("R1/R5 m%0d mk%0d r%0d l%0d", m, mk, r, l),
                                 (l == r) && (mk == 0));
                        mask = 1'b0;
                        swr(1'b0);
                    end

        // R4: width in strobes for several spacings
        irq_mode = 1'b0;
        rate_sel = 2'd1;
        for (int p = 1; p < 4; p++) begin
            fire(1);
            chk_flag("R4 start", 1'b1);
            measure(p, t);
            chk($sformatf("R4 width period %0d", p), t, PT);
            chk_flag("R4 released", 1'b0);
        end

        // R4: early release by write 0
        fire(1);
        step(1'b1);
        step(1'b1);
        swr(1'b0);
        chk_flag("R4 early release", 1'b0);

        // R8: event during pulse does not extend it
        fire(1);
        for (int k = 0; k < PT / 2; k++) step(1'b1);
        fire(1);
        measure(1, t);
        chk("R8 no extend", t, PT - PT / 2);

        // R6: stop freezes and resumes
        fire(1);
        for (int k = 0; k < 3; k++) step(1'b1);
        stop = 1'b1;
        for (int k = 0; k < 3 * PT; k++) step(1'b1);
        chk_flag("R6 frozen low", 1'b1);
        stop = 1'b0;
        measure(2, t);
        chk("R6 remaining count", t, PT - 3);
        stop = 1'b1;
        fire(1);
        chk_flag("R6 event blocked", 1'b0);
        stop = 1'b0;
        fire(1);
        stop = 1'b1;
        swr(1'b0);
        chk_flag("R7 clear under stop", 1'b0);
        stop = 1'b0;

        // R3: latched mode holds
        irq_mode = 1'b1;
        fire(1);
        for (int k = 0; k < 3 * PT; k++) step(1'b1);
        chk_flag("R3 held", 1'b1);
        mask = 1'b1;
        step(1'b1);
        chk_flag("R5 mask keeps pending", 1'b1);
        mask = 1'b0;
        fire(1);
        swr(1'b1);
        chk_flag("R7 write 1 no clear", 1'b1);
        swr(1'b0);
        chk_flag("R7 write 0 clears", 1'b0);
        step(1'b1);
        step(1'b0);
        chk_flag("R8 no latent event", 1'b0);

        // R8: clear and event in the same cycle
        fire(1);
        evt_sec = 1'b1;
        swr(1'b0);
        evt_sec = 1'b0;
        chk_flag("R8 same-cycle clear", 1'b0);

        // R7: write 1 while idle
        swr(1'b1);
        chk_flag("R7 write 1 no set", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule